// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Acknowledge Unit

This unit sits on the system bus between a set of maskable device request lines, one non-maskable request line and a processor core. Each cycle it picks the most urgent request whose priority is above the level the core is running at. It then raises an interrupt to the core. When the core gives its go-ahead, the unit acknowledges exactly one device and waits for that device to place a vector number on the data bus.

If a vector arrives, the unit reports the handler's table-entry address, computed as table base plus four times the vector. It also raises the core's running level to the accepted one and saves the previous level on a small stack. A return-from-interrupt strobe from the core restores the saved level. If no vector arrives within the timeout window, the unit reports a bus error and leaves the running level untouched.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset `cpu_irq`, every acknowledge output, `handler_valid` and `bus_err` are low, and `cur_level` is 0.
- R2: Maskable line i carries priority level NUM_LINES−i, and level 0 means no handler is running. A maskable line is eligible only while its level is strictly greater than `cur_level`. When nothing is eligible, `cpu_irq` stays low and the request is held off.
- R3: When several eligible lines are asserted together, the lowest-numbered line wins. Line 0 is therefore the most urgent.
- R4: Acknowledge rises only on the clock edge after `cpu_go` is sampled high together with `cpu_irq`. It is one-hot over {`nmi_ack`, `dev_ack`} and is held until a vector is sampled or the window expires.
- R5: When `vec_valid` is sampled during acknowledge, `handler_valid` is high for exactly the next cycle and acknowledge drops at the same edge. `handler_addr` equals `tbl_base` + 4·`vec_data`, modulo 2^ADDR_W.
- R6: Acknowledge without a vector lasts exactly TIMEOUT cycles, which is 16 by default. The unit then pulses `bus_err` for one cycle and produces no handler address, and `cur_level` does not change.
- R7: A request withdrawn before the core's go-ahead is abandoned. `cpu_irq` falls, no acknowledge is driven and no bus error follows.
- R8: The non-maskable line has level NUM_LINES+1 and wins over every maskable line at any running level. A second non-maskable request waits while a non-maskable handler is running.
- R9: On vector receipt `cur_level` becomes the accepted level, and the previous level is saved for restoration.
- R10: `cpu_rti` sampled while the unit is idle restores the most recently saved level. With nothing saved it leaves `cur_level` at 0. `cpu_rti` sampled during acknowledge has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | NUM_LINES | Maskable device request lines, line 0 most urgent |
| nmi_req | input | 1 | Non-maskable request |
| cpu_go | input | 1 | Core is ready to take the offered interrupt |
| cpu_rti | input | 1 | Core returns from the current handler |
| vec_valid | input | 1 | Acknowledged device drives a vector this cycle |
| vec_data | input | VEC_W | Vector number from the device |
| tbl_base | input | ADDR_W | Base address of the vector table |
| cpu_irq | output | 1 | Interrupt offered to the core |
| dev_ack | output | NUM_LINES | One-hot acknowledge to maskable devices |
| nmi_ack | output | 1 | Acknowledge to the non-maskable source |
| handler_valid | output | 1 | One-cycle strobe: handler address is valid |
| handler_addr | output | ADDR_W | Vector-table entry address |
| bus_err | output | 1 | One-cycle strobe: vector timeout |
| cur_level | output | LVL_W | Priority level the core is running at |

## Verification
A lone request at the lowest level tests the basic handshake and the address arithmetic. Two requests asserted together separate fixed-priority selection from arbitrary picking. Repeating a request at the running level tests masking against the current level. A non-maskable request arriving on top of the highest maskable level tests the bypass, and a second one arriving inside its own handler tests its self-hold. A withheld vector and a request withdrawn before go-ahead separate the bus-error path from plain abandonment. A return strobe issued during acknowledge and another issued with an empty stack test that the level stack moves only when it should.

// File: rtl/irq_vector_unit_pkg.sv
package irq_vector_unit_pkg;
   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_ACK  = 1'b1
   } ivu_state_e;
endpackage

// File: rtl/ivu_prio_sel.sv
module ivu_prio_sel #(
   parameter int NUM_LINES = 3,
   parameter int LVL_W     = 3,
   parameter int IDX_W     = 2
) (
   input  logic [NUM_LINES-1:0] req,
   input  logic                 nmi,
   input  logic [LVL_W-1:0]     cur,
   output logic                 win_valid,
   output logic                 win_nmi,
   output logic [IDX_W-1:0]     win_idx,
   output logic [LVL_W-1:0]     win_lvl
);
   localparam logic [LVL_W-1:0] NMI_LVL = LVL_W'(NUM_LINES + 1);

   logic [NUM_LINES-1:0] elig;
   logic                 nmi_ok;

   for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_elig
      localparam logic [LVL_W-1:0] LINE_LVL = LVL_W'(NUM_LINES - gi);
      assign elig[gi] = req[gi] && (LINE_LVL > cur);
   end

   assign nmi_ok = nmi && (cur != NMI_LVL);

   always_comb begin
      win_idx = '0;
      win_lvl = '0;
      for (int i = NUM_LINES - 1; i >= 0; i--) begin
         if (elig[i]) begin
            win_idx = IDX_W'(i);
            win_lvl = LVL_W'(NUM_LINES - i);
         end
      end
      win_nmi = nmi_ok;
      if (nmi_ok) begin
         win_lvl = NMI_LVL;
         win_idx = '0;
      end
      win_valid = nmi_ok || (|elig);
   end
endmodule

// File: rtl/ivu_ack_timer.sv
module ivu_ack_timer #(
   parameter int TIMEOUT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   output logic expired
);
   localparam int CNT_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (start) begin
         cnt <= '0;
      end else if (run && (cnt != LAST)) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign expired = run && (cnt == LAST);
endmodule

// File: rtl/ivu_level_stack.sv
module ivu_level_stack #(
   parameter int DEPTH = 4,
   parameter int LVL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [LVL_W-1:0] new_lvl,
   input  logic             pop,
   output logic [LVL_W-1:0] cur_lvl
);
   localparam int SP_W = $clog2(DEPTH + 1);

   logic [LVL_W-1:0] saved [DEPTH];
   logic [SP_W-1:0]  sp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp      <= '0;
         cur_lvl <= '0;
      end else if (push && (sp != SP_W'(DEPTH))) begin
         saved[sp[$clog2(DEPTH)-1:0]] <= cur_lvl;
         sp      <= sp + 1'b1;
         cur_lvl <= new_lvl;
      end else if (pop && (sp != '0)) begin
         sp      <= sp - 1'b1;
         cur_lvl <= saved[$clog2(DEPTH)'(sp - 1'b1)];
      end
   end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
   import irq_vector_unit_pkg::*;
#(
   parameter int NUM_LINES   = 3,
   parameter int VEC_W       = 8,
   parameter int ADDR_W      = 16,
   parameter int TIMEOUT     = 16,
   parameter int STACK_DEPTH = 4,
   parameter int LVL_W       = $clog2(NUM_LINES + 2)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] dev_req,
   input  logic                 nmi_req,
   input  logic                 cpu_go,
   input  logic                 cpu_rti,
   input  logic                 vec_valid,
   input  logic [VEC_W-1:0]     vec_data,
   input  logic [ADDR_W-1:0]    tbl_base,
   output logic                 cpu_irq,
   output logic [NUM_LINES-1:0] dev_ack,
   output logic                 nmi_ack,
   output logic                 handler_valid,
   output logic [ADDR_W-1:0]    handler_addr,
   output logic                 bus_err,
   output logic [LVL_W-1:0]     cur_level
);
   localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

   if (NUM_LINES < 1) begin : g_bad_lines
      $error("NUM_LINES must be at least 1");
   end
   if (STACK_DEPTH < NUM_LINES + 1) begin : g_bad_depth
      $error("STACK_DEPTH must cover every nesting level");
   end
   if (ADDR_W < VEC_W + 2) begin : g_bad_addr
      $error("ADDR_W too narrow for scaled vector");
   end
   if (TIMEOUT < 2) begin : g_bad_to
      $error("TIMEOUT must be at least 2");
   end
   if (LVL_W < $clog2(NUM_LINES + 2)) begin : g_bad_lvl
      $error("LVL_W too narrow for the non-maskable level");
   end

   ivu_state_e       state;
   logic             win_valid, win_nmi;
   logic [IDX_W-1:0] win_idx;
   logic [LVL_W-1:0] win_lvl;
   logic             sel_nmi;
   logic [IDX_W-1:0] sel_idx;
   logic [LVL_W-1:0] sel_lvl;
   logic             take, in_ack, got_vec, expired, push, pop;

   ivu_prio_sel #(
      .NUM_LINES (NUM_LINES),
      .LVL_W     (LVL_W),
      .IDX_W     (IDX_W)
   ) u_sel (
      .req       (dev_req),
      .nmi       (nmi_req),
      .cur       (cur_level),
      .win_valid (win_valid),
      .win_nmi   (win_nmi),
      .win_idx   (win_idx),
      .win_lvl   (win_lvl)
   );

   assign in_ack  = (state == ST_ACK);
   assign cpu_irq = (state == ST_IDLE) && win_valid;
   assign take    = cpu_irq && cpu_go;
   assign got_vec = in_ack && vec_valid;
   assign push    = got_vec;
   assign pop     = (state == ST_IDLE) && cpu_rti;

   ivu_ack_timer #(
      .TIMEOUT (TIMEOUT)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (take),
      .run     (in_ack),
      .expired (expired)
   );

   ivu_level_stack #(
      .DEPTH   (STACK_DEPTH),
      .LVL_W   (LVL_W)
   ) u_stack (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (push),
      .new_lvl (sel_lvl),
      .pop     (pop),
      .cur_lvl (cur_level)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         sel_nmi <= 1'b0;
         sel_idx <= '0;
         sel_lvl <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (take) begin
                  state   <= ST_ACK;
                  sel_nmi <= win_nmi;
                  sel_idx <= win_idx;
                  sel_lvl <= win_lvl;
               end
            end
            ST_ACK: begin
               if (vec_valid || expired) begin
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         handler_valid <= 1'b0;
         handler_addr  <= '0;
         bus_err       <= 1'b0;
      end else begin
         handler_valid <= got_vec;
         bus_err       <= expired && !vec_valid;
         if (got_vec) begin
            handler_addr <= tbl_base + (ADDR_W'(vec_data) << 2);
         end
      end
   end

   assign nmi_ack = in_ack && sel_nmi;

   for (genvar gl = 0; gl < NUM_LINES; gl++) begin : g_ack
      assign dev_ack[gl] = in_ack && !sel_nmi && (sel_idx == IDX_W'(gl));
   end
endmodule

// File: rtl/irq_vector_unit_chk.sv
module irq_vector_unit_chk #(
   parameter int NUM_LINES = 3,
   parameter int TIMEOUT   = 16,
   parameter int LVL_W     = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cpu_irq,
   input logic                 cpu_go,
   input logic [NUM_LINES-1:0] dev_ack,
   input logic                 nmi_ack,
   input logic                 vec_valid,
   input logic                 handler_valid,
   input logic                 bus_err,
   input logic [LVL_W-1:0]     cur_level
);
   localparam int RUN_W = $clog2(TIMEOUT + 2);

   logic             ack_any;
   logic [RUN_W-1:0] ack_run;

   assign ack_any = nmi_ack || (|dev_ack);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_run <= '0;
      end else if (!ack_any) begin
         ack_run <= '0;
      end else if (ack_run != RUN_W'(TIMEOUT + 1)) begin
         ack_run <= ack_run + 1'b1;
      end
   end

   a_r4_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({nmi_ack, dev_ack}));

   a_r4_ack_after_go: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_any && !$past(ack_any)) |-> $past(cpu_go && cpu_irq));

   a_r5_handler_after_vec: assert property (@(posedge clk) disable iff (!rst_n)
      handler_valid |-> $past(vec_valid && ack_any));

   a_r5_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
      handler_valid |-> !ack_any);

   a_r6_err_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> ($past(ack_any) && !handler_valid));

   a_r6_err_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> $stable(cur_level));

   a_r6_ack_window: assert property (@(posedge clk) disable iff (!rst_n)
      ack_run <= RUN_W'(TIMEOUT));

   a_r9_level_rises: assert property (@(posedge clk) disable iff (!rst_n)
      handler_valid |-> (cur_level > $past(cur_level)));
endmodule

bind irq_vector_unit irq_vector_unit_chk #(
   .NUM_LINES (NUM_LINES),
   .TIMEOUT   (TIMEOUT),
   .LVL_W     (LVL_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cpu_irq       (cpu_irq),
   .cpu_go        (cpu_go),
   .dev_ack       (dev_ack),
   .nmi_ack       (nmi_ack),
   .vec_valid     (vec_valid),
   .handler_valid (handler_valid),
   .bus_err       (bus_err),
   .cur_level     (cur_level)
);

// File: tb/irq_vector_unit_test.sv
module irq_vector_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 3;
   localparam int VW = 8;
   localparam int AW = 16;
   localparam int LW = 3;

   typedef struct {
      bit          is_err;
      logic [AW-1:0] addr;
      string       tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  dev_req = '0;
   logic          nmi_req = 1'b0;
   logic          cpu_go = 1'b0;
   logic          cpu_rti = 1'b0;
   logic          vec_valid = 1'b0;
   logic [VW-1:0] vec_data = '0;
   logic [AW-1:0] tbl_base = 16'h4000;
   logic          cpu_irq;
   logic [N-1:0]  dev_ack;
   logic          nmi_ack;
   logic          handler_valid;
   logic [AW-1:0] handler_addr;
   logic          bus_err;
   logic [LW-1:0] cur_level;

   int   n_tests = 0;
   int   n_fail  = 0;
   bit   done    = 1'b0;
   exp_t sb[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   irq_vector_unit uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .dev_req       (dev_req),
      .nmi_req       (nmi_req),
      .cpu_go        (cpu_go),
      .cpu_rti       (cpu_rti),
      .vec_valid     (vec_valid),
      .vec_data      (vec_data),
      .tbl_base      (tbl_base),
      .cpu_irq       (cpu_irq),
      .dev_ack       (dev_ack),
      .nmi_ack       (nmi_ack),
      .handler_valid (handler_valid),
      .handler_addr  (handler_addr),
      .bus_err       (bus_err),
      .cur_level     (cur_level)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic int ack_word();
      return {nmi_ack, dev_ack};
   endfunction

   // Scoreboard monitor: handler and bus-error strobes are matched in order.
   always @(negedge clk) begin
      if (rst_n && (handler_valid || bus_err)) begin
         if (sb.size() == 0) begin
            check(1'b0, "R7 unexpected event", {handler_valid, bus_err}, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (e.is_err) begin
               check(bus_err && !handler_valid, e.tag, {handler_valid, bus_err}, 1);
            end else begin
               check(handler_valid && !bus_err && (handler_addr == e.addr),
                     e.tag, int'(handler_addr), int'(e.addr));
            end
         end
      end
   end

   task automatic expect_handler(input logic [VW-1:0] v, input string tag);
      exp_t e;
      e.is_err = 1'b0;
      e.addr   = tbl_base + AW'(int'(v) * 4);
      e.tag    = tag;
      sb.push_back(e);
   endtask

   task automatic run_isr(input logic [N-1:0] reqs, input bit nmi, input int exp_ack,
                          input logic [VW-1:0] v, input int delay, input int exp_lvl);
      dev_req = reqs;
      nmi_req = nmi;
      #1;
      check(cpu_irq == 1'b1, "R2 irq offered", cpu_irq, 1);
      cpu_go = 1'b1;
      tick();
      cpu_go = 1'b0;
      check(ack_word() == exp_ack, "R3 R4 ack selection", ack_word(), exp_ack);
      repeat (delay) tick();
      check(ack_word() == exp_ack, "R4 ack held", ack_word(), exp_ack);
      expect_handler(v, "R5 handler address");
      vec_valid = 1'b1;
      vec_data  = v;
      tick();
      vec_valid = 1'b0;
      dev_req   = '0;
      nmi_req   = 1'b0;
      check(ack_word() == 0, "R5 ack dropped", ack_word(), 0);
      check(cur_level == LW'(exp_lvl), "R9 level raised", cur_level, exp_lvl);
   endtask

   task automatic rti_expect(input int exp_lvl, input string tag);
      cpu_rti = 1'b1;
      tick();
      cpu_rti = 1'b0;
      check(cur_level == LW'(exp_lvl), tag, cur_level, exp_lvl);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(cpu_irq == 0, "R1 irq", cpu_irq, 0);
      check(ack_word() == 0, "R1 ack", ack_word(), 0);
      check(!handler_valid && !bus_err, "R1 strobes", {handler_valid, bus_err}, 0);
      check(cur_level == 0, "R1 level", cur_level, 0);

      // Lowest line alone: level 1
      run_isr(3'b100, 1'b0, 4'b0100, 8'h21, 2, 1);
      tick();

      // R2: same level is held off, go has no effect
      dev_req = 3'b100;
      #1;
      check(cpu_irq == 0, "R2 masked at equal level", cpu_irq, 0);
      cpu_go = 1'b1;
      tick();
      cpu_go = 1'b0;
      check(ack_word() == 0, "R2 no ack when masked", ack_word(), 0);
      dev_req = '0;

      // R3: lines 0 and 1 together, line 0 wins (level 3)
      run_isr(3'b011, 1'b0, 4'b0001, 8'h05, 0, 3);
      tick();

      // R8 + R10: NMI above top maskable level, rti during ack ignored
      nmi_req = 1'b1;
      dev_req = 3'b001;
      #1;
      check(cpu_irq == 1, "R8 nmi unmasked", cpu_irq, 1);
      cpu_go = 1'b1;
      tick();
      cpu_go  = 1'b0;
      dev_req = '0;
      check(ack_word() == 4'b1000, "R8 nmi ack", ack_word(), 8);
      cpu_rti = 1'b1;
      tick();
      cpu_rti = 1'b0;
      check(cur_level == 3, "R10 rti ignored in ack", cur_level, 3);
      expect_handler(8'hFF, "R5 nmi handler address");
      vec_valid = 1'b1;
      vec_data  = 8'hFF;
      tick();
      vec_valid = 1'b0;
      nmi_req   = 1'b0;
      check(cur_level == 4, "R8 R9 nmi level", cur_level, 4);
      tick();
      nmi_req = 1'b1;
      #1;
      check(cpu_irq == 0, "R8 second nmi held", cpu_irq, 0);
      nmi_req = 1'b0;

      // R10 pops back through the saved levels
      rti_expect(3, "R10 pop to 3");
      rti_expect(1, "R10 pop to 1");
      rti_expect(0, "R10 pop to 0");
      rti_expect(0, "R10 empty pop");

      // R6 timeout on line 1
      dev_req = 3'b010;
      #1;
      cpu_go = 1'b1;
      tick();
      cpu_go = 1'b0;
      check(ack_word() == 4'b0010, "R4 ack line 1", ack_word(), 2);
      repeat (15) tick();
      check(ack_word() == 4'b0010, "R6 ack held 16 cycles", ack_word(), 2);
      begin
         exp_t e;
         e.is_err = 1'b1;
         e.addr   = '0;
         e.tag    = "R6 bus error";
         sb.push_back(e);
      end
      tick();
      dev_req = '0;
      check(ack_word() == 0, "R6 ack released", ack_word(), 0);
      check(cur_level == 0, "R6 level unchanged", cur_level, 0);
      tick();

      // R7 abandon before go-ahead
      dev_req = 3'b001;
      #1;
      check(cpu_irq == 1, "R7 irq raised", cpu_irq, 1);
      tick();
      dev_req = '0;
      #1;
      check(cpu_irq == 0, "R7 irq withdrawn", cpu_irq, 0);
      cpu_go = 1'b1;
      tick();
      cpu_go = 1'b0;
      check(ack_word() == 0, "R7 no ack", ack_word(), 0);
      repeat (20) tick();
      check(ack_word() == 0 && cur_level == 0, "R7 idle", ack_word(), 0);

      // R8: NMI and line 0 together at level 0
      run_isr(3'b001, 1'b1, 4'b1000, 8'h02, 1, 4);
      rti_expect(0, "R10 return after nmi");

      repeat (3) tick();
      check(sb.size() == 0, "R5 R6 all events seen", sb.size(), 0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule